// File: doc/BRIEF.md
# SCSI Host DMA Channel Register Block

This block holds the host-visible registers of a bus-master DMA channel that sits next to a SCSI protocol core. A host reaches eight 32-bit registers through a single-cycle register port. The registers are a command word, three programmed start values (byte count, physical address and descriptor-list address), their three working copies, and a status word. Writing a command turns its two-bit operation code into controls for the transfer engine: enable, disable, or a one-cycle abort pulse. The start operation loads the working copies from the programmed values.

The transfer engine asks for chunks with a length and a direction. The block clips each chunk to the remaining working byte count and rejects a chunk whose direction does not match the command. It then lowers the working count and raises the working address by the granted length. A completion from the SCSI core zeroes the working count and sets the done flag. The status word is cleared in one of two ways. An external control bit selects write-one-to-clear or clear-on-read. The SCSI-interrupt status bit is a live copy of the core's interrupt line.

Top module: `dma_chan_regs`

## Requirements
- R1: After reset the command, start count, start address, start list address, working count and status read as 0. The working address reads FFFFFFFF, the working list address reads FFFFFFFD, and `dma_en_o` and `abort_o` are low.
- R2: Register indices are 0 command, 1 start count, 2 start address, 3 working count, 4 working address, 5 status, 6 start list address and 7 working list address. Indices 0, 1, 2 and 6 read back what was written. Writes to indices 3, 4 and 7 are ignored.
- R3: A command write with bits [1:0] = 3 (start) does four things from the next cycle: it copies index 1 to 3, index 2 to 4 and index 6 to 7; it clears status bits [5:0]; it raises `dma_en_o`; and it sets `to_mem_o` to command bit 7.
- R4: Command code 0 (idle) drops `dma_en_o`. Code 1 (flush) changes no output and no register other than the command word.
- R5: Command code 2 raises `abort_o` for exactly the one cycle after the write, and `dma_en_o` is unchanged.
- R6: `chunk_grant_o` equals the smaller of `chunk_len_i` and the working count.
- R7: After an accepted chunk, the working count is lower and the working address is higher, each by the granted length.
- R8: A chunk whose `chunk_to_mem_i` differs from command bit 7 (1 = device to memory) gives `chunk_ok_o` low and leaves every counter unchanged.
- R9: A `core_done_i` pulse sets the working count to 0 and sets status bit 3 (done).
- R10: With `rd_clr_mode_i` low, a status write clears those of bits 1 (error), 2 (abort) and 3 (done) that are written as 1, and no other bit.
- R11: With `rd_clr_mode_i` high, status writes have no effect. A status read returns the current value and then clears bits 1, 2 and 3.
- R12: Status bit 4 reads as `core_irq_i` and is not stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_re_i | input | 1 | Register read strobe |
| reg_idx_i | input | 3 | Register index |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for `reg_idx_i` |
| rd_clr_mode_i | input | 1 | 1 = status clears on read, 0 = write-one-to-clear |
| core_irq_i | input | 1 | SCSI core interrupt flag |
| core_done_i | input | 1 | SCSI core command completion pulse |
| chunk_req_i | input | 1 | Transfer chunk request |
| chunk_to_mem_i | input | 1 | Chunk direction, 1 = device to memory |
| chunk_len_i | input | 16 | Requested chunk length in bytes |
| chunk_ok_o | output | 1 | Chunk accepted |
| chunk_grant_o | output | 16 | Granted chunk length |
| dma_en_o | output | 1 | DMA enable to the transfer engine |
| abort_o | output | 1 | One-cycle abort pulse |
| to_mem_o | output | 1 | Current direction from command bit 7 |

## Verification
The hardest cases to reach are the clip boundary and the two status-clear policies. To reach the boundary, a series of chunks wears the working count down until a request is longer than what remains, and then one more request arrives with nothing left. For the status policies, done is raised by a core pulse before each status access, so every clear path starts from a set bit. The same access is then repeated under the other mode. The stimulus also reads back the status a second time, so that clear-on-read shows its effect only on the later read.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;
  typedef enum logic [2:0] {
    IX_CMD  = 3'd0,
    IX_SCNT = 3'd1,
    IX_SADR = 3'd2,
    IX_WCNT = 3'd3,
    IX_WADR = 3'd4,
    IX_STAT = 3'd5,
    IX_SLST = 3'd6,
    IX_WLST = 3'd7
  } reg_ix_e;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_FLUSH = 2'd1,
    OP_ABORT = 2'd2,
    OP_GO    = 2'd3
  } dma_op_e;

  localparam int CMD_DIR_BIT = 7;
  localparam int ST_W        = 6;
  localparam int ST_IRQ      = 4;
  localparam int ST_DONE     = 3;
  localparam logic [ST_W-1:0] ST_CLR_MASK = 6'b001110;
endpackage

// File: rtl/dma_cmd_ctrl.sv
module dma_cmd_ctrl #(
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] cmd_o,
  output logic          go_o,
  output logic          dma_en_o,
  output logic          abort_o
);
  import dma_chan_pkg::*;

  dma_op_e op;
  assign op   = dma_op_e'(wdata_i[1:0]);
  assign go_o = wr_i && (op == OP_GO);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_o    <= '0;
      dma_en_o <= 1'b0;
      abort_o  <= 1'b0;
    end else begin
      abort_o <= wr_i && (op == OP_ABORT);
      if (wr_i) begin
        cmd_o <= wdata_i;
        if (op == OP_IDLE)    dma_en_o <= 1'b0;
        else if (op == OP_GO) dma_en_o <= 1'b1;
      end
    end
  end

  // R5
  abort_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |-> $past(wr_i && wdata_i[1:0] == 2'd2));
  // R3
  go_enables_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go_o |=> dma_en_o);
  // R4
  idle_disables_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && wdata_i[1:0] == 2'd0) |=> !dma_en_o);
endmodule

// File: rtl/dma_work_cnt.sv
module dma_work_cnt #(
  parameter int DW = 32,
  parameter int LW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [2:0]    idx_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          go_i,
  input  logic          done_i,
  input  logic          cmd_to_mem_i,
  input  logic          req_i,
  input  logic          req_to_mem_i,
  input  logic [LW-1:0] len_i,
  output logic          ok_o,
  output logic [LW-1:0] grant_o,
  output logic [DW-1:0] scnt_o,
  output logic [DW-1:0] sadr_o,
  output logic [DW-1:0] slst_o,
  output logic [DW-1:0] wcnt_o,
  output logic [DW-1:0] wadr_o,
  output logic [DW-1:0] wlst_o
);
  import dma_chan_pkg::*;

  localparam logic [DW-1:0] WADR_RST = '1;
  localparam logic [DW-1:0] WLST_RST = ~DW'(2);

  reg_ix_e ix;
  logic    adv;
  assign ix      = reg_ix_e'(idx_i);
  assign grant_o = (wcnt_o < DW'(len_i)) ? wcnt_o[LW-1:0] : len_i;
  assign ok_o    = req_i && (req_to_mem_i == cmd_to_mem_i) && !go_i && !done_i;
  assign adv     = ok_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scnt_o <= '0;
      sadr_o <= '0;
      slst_o <= '0;
    end else if (wr_i) begin
      if (ix == IX_SCNT) scnt_o <= wdata_i;
      if (ix == IX_SADR) sadr_o <= wdata_i;
      if (ix == IX_SLST) slst_o <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wcnt_o <= '0;
      wadr_o <= WADR_RST;
      wlst_o <= WLST_RST;
    end else begin
      if (done_i)   wcnt_o <= '0;
      else if (go_i) wcnt_o <= scnt_o;
      else if (adv)  wcnt_o <= wcnt_o - DW'(grant_o);
      if (go_i) begin
        wadr_o <= sadr_o;
        wlst_o <= slst_o;
      end else if (adv) begin
        wadr_o <= wadr_o + DW'(grant_o);
      end
    end
  end

  // R7
  sum_kept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv |=> (wadr_o + wcnt_o) == $past(wadr_o + wcnt_o));
  // R8
  reject_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !ok_o && !go_i && !done_i) |=>
      ($stable(wcnt_o) && $stable(wadr_o) && $stable(wlst_o)));
  // R9
  done_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> (wcnt_o == '0));
endmodule

// File: rtl/dma_stat_reg.sv
module dma_stat_reg
  import dma_chan_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_i,
  input  logic            rd_i,
  input  logic            rd_clr_mode_i,
  input  logic [ST_W-1:0] wdata_i,
  input  logic            go_i,
  input  logic            done_i,
  input  logic            core_irq_i,
  output logic [ST_W-1:0] view_o
);
  logic [ST_W-1:0] stat_q, stat_d;

  always_comb begin
    stat_d = stat_q;
    if (go_i) stat_d = '0;
    if (wr_i && !rd_clr_mode_i) stat_d = stat_d & ~(wdata_i & ST_CLR_MASK);
    if (rd_i && rd_clr_mode_i)  stat_d = stat_d & ~ST_CLR_MASK;
    if (done_i) stat_d[ST_DONE] = 1'b1;
    stat_d[ST_IRQ] = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stat_q <= '0;
    else         stat_q <= stat_d;
  end

  always_comb begin
    view_o         = stat_q;
    view_o[ST_IRQ] = core_irq_i;
  end

  // R11
  rc_write_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && rd_clr_mode_i && !rd_i && !go_i && !done_i) |=> $stable(stat_q));
  // R9
  done_sets_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> stat_q[ST_DONE]);
endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs #(
  parameter int DW = 32,
  parameter int LW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          reg_we_i,
  input  logic          reg_re_i,
  input  logic [2:0]    reg_idx_i,
  input  logic [DW-1:0] reg_wdata_i,
  output logic [DW-1:0] reg_rdata_o,
  input  logic          rd_clr_mode_i,
  input  logic          core_irq_i,
  input  logic          core_done_i,
  input  logic          chunk_req_i,
  input  logic          chunk_to_mem_i,
  input  logic [LW-1:0] chunk_len_i,
  output logic          chunk_ok_o,
  output logic [LW-1:0] chunk_grant_o,
  output logic          dma_en_o,
  output logic          abort_o,
  output logic          to_mem_o
);
  import dma_chan_pkg::*;

  reg_ix_e         ix;
  logic [DW-1:0]   cmd_q, scnt, sadr, slst, wcnt, wadr, wlst;
  logic [ST_W-1:0] stat_view;
  logic            go;

  assign ix       = reg_ix_e'(reg_idx_i);
  assign to_mem_o = cmd_q[CMD_DIR_BIT];

  dma_cmd_ctrl #(.DW(DW)) u_cmd (
    .clk_i, .rst_ni,
    .wr_i     (reg_we_i && ix == IX_CMD),
    .wdata_i  (reg_wdata_i),
    .cmd_o    (cmd_q),
    .go_o     (go),
    .dma_en_o (dma_en_o),
    .abort_o  (abort_o)
  );

  dma_work_cnt #(.DW(DW), .LW(LW)) u_cnt (
    .clk_i, .rst_ni,
    .wr_i         (reg_we_i),
    .idx_i        (reg_idx_i),
    .wdata_i      (reg_wdata_i),
    .go_i         (go),
    .done_i       (core_done_i),
    .cmd_to_mem_i (cmd_q[CMD_DIR_BIT]),
    .req_i        (chunk_req_i),
    .req_to_mem_i (chunk_to_mem_i),
    .len_i        (chunk_len_i),
    .ok_o         (chunk_ok_o),
    .grant_o      (chunk_grant_o),
    .scnt_o       (scnt),
    .sadr_o       (sadr),
    .slst_o       (slst),
    .wcnt_o       (wcnt),
    .wadr_o       (wadr),
    .wlst_o       (wlst)
  );

  dma_stat_reg u_stat (
    .clk_i, .rst_ni,
    .wr_i          (reg_we_i && ix == IX_STAT),
    .rd_i          (reg_re_i && ix == IX_STAT),
    .rd_clr_mode_i (rd_clr_mode_i),
    .wdata_i       (reg_wdata_i[ST_W-1:0]),
    .go_i          (go),
    .done_i        (core_done_i),
    .core_irq_i    (core_irq_i),
    .view_o        (stat_view)
  );

  always_comb begin
    unique case (ix)
      IX_CMD:  reg_rdata_o = cmd_q;
      IX_SCNT: reg_rdata_o = scnt;
      IX_SADR: reg_rdata_o = sadr;
      IX_WCNT: reg_rdata_o = wcnt;
      IX_WADR: reg_rdata_o = wadr;
      IX_STAT: reg_rdata_o = {{(DW-ST_W){1'b0}}, stat_view};
      IX_SLST: reg_rdata_o = slst;
      IX_WLST: reg_rdata_o = wlst;
      default: reg_rdata_o = '0;
    endcase
  end
endmodule

// File: tb/tb_dma_chan_regs.sv
`timescale 1ns/1ps
module tb_dma_chan_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 0, re = 0;
  logic [2:0]  idx = 0;
  logic [31:0] wdata = 0, rdata;
  logic        rc_mode = 0, irq = 0, done = 0;
  logic        req = 0, req_mem = 0;
  logic [15:0] len = 0, grant;
  logic        ok, en, abt, to_mem;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  dma_chan_regs dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_re_i(re),
    .reg_idx_i(idx), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .rd_clr_mode_i(rc_mode), .core_irq_i(irq), .core_done_i(done),
    .chunk_req_i(req), .chunk_to_mem_i(req_mem), .chunk_len_i(len),
    .chunk_ok_o(ok), .chunk_grant_o(grant), .dma_en_o(en),
    .abort_o(abt), .to_mem_o(to_mem)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] i, input logic [31:0] d);
    @(negedge clk); we = 1; idx = i; wdata = d;
    @(negedge clk); we = 0;
  endtask

  task automatic rd(input logic [2:0] i, output logic [31:0] d);
    @(negedge clk); re = 1; idx = i; #1 d = rdata;
    @(negedge clk); re = 0;
  endtask

  task automatic rchk(input string tag, input logic [2:0] i, input logic [31:0] exp);
    logic [31:0] d;
    rd(i, d);
    chk(tag, d, exp);
  endtask

  task automatic pulse_done();
    @(negedge clk); done = 1;
    @(negedge clk); done = 0;
  endtask

  task automatic chunk(input logic m, input logic [15:0] l,
                       input logic exp_ok, input logic [15:0] exp_g);
    @(negedge clk); req = 1; req_mem = m; len = l; #1;
    chk("R8 chunk_ok", 32'(ok), 32'(exp_ok));
    chk("R6 grant", 32'(grant), 32'(exp_g));
    @(negedge clk); req = 0;
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] ewc, ewa, d;
    logic [15:0] g;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset values
    chk("R1 dma_en", 32'(en), 0);
    chk("R1 abort", 32'(abt), 0);
    rchk("R1 cmd", 0, 0);  rchk("R1 scnt", 1, 0); rchk("R1 sadr", 2, 0);
    rchk("R1 wcnt", 3, 0); rchk("R1 wadr", 4, 32'hFFFF_FFFF);
    rchk("R1 stat", 5, 0); rchk("R1 slst", 6, 0); rchk("R1 wlst", 7, 32'hFFFF_FFFD);

    // R2 programmed regs read back, working regs ignore writes
    wr(1, 32'h40); wr(2, 32'h1000); wr(6, 32'hABC);
    wr(3, 32'h1234); wr(4, 32'h5555); wr(7, 32'h7777);
    rchk("R2 scnt", 1, 32'h40); rchk("R2 sadr", 2, 32'h1000); rchk("R2 slst", 6, 32'hABC);
    rchk("R2 wcnt", 3, 0); rchk("R2 wadr", 4, 32'hFFFF_FFFF); rchk("R2 wlst", 7, 32'hFFFF_FFFD);

    // R3 start to memory
    wr(0, 32'h83);
    chk("R3 dma_en", 32'(en), 1);
    chk("R3 to_mem", 32'(to_mem), 1);
    rchk("R3 wcnt", 3, 32'h40); rchk("R3 wadr", 4, 32'h1000); rchk("R3 wlst", 7, 32'hABC);
    rchk("R2 cmd", 0, 32'h83);

    // R6 R7 chunk sweep down to and past the clip boundary
    ewc = 32'h40; ewa = 32'h1000;
    foreach (len_list[k]) begin
      g = (ewc < 32'(len_list[k])) ? ewc[15:0] : len_list[k];
      chunk(1'b1, len_list[k], 1'b1, g);
      ewc = ewc - 32'(g); ewa = ewa + 32'(g);
      rchk("R7 wcnt", 3, ewc); rchk("R7 wadr", 4, ewa);
    end

    // R8 direction mismatch
    wr(1, 32'h20); wr(2, 32'h2000);
    wr(0, 32'h03);
    chk("R3 to_mem dev", 32'(to_mem), 0);
    chunk(1'b1, 16'd4, 1'b0, 16'd4);
    rchk("R8 wcnt kept", 3, 32'h20); rchk("R8 wadr kept", 4, 32'h2000);
    chunk(1'b0, 16'd4, 1'b1, 16'd4);
    rchk("R7 wcnt dev", 3, 32'h1C); rchk("R7 wadr dev", 4, 32'h2004);

    // R5 abort pulse
    @(negedge clk); we = 1; idx = 0; wdata = 32'h02;
    @(negedge clk); we = 0;
    chk("R5 abort high", 32'(abt), 1);
    chk("R5 en kept", 32'(en), 1);
    @(negedge clk);
    chk("R5 abort low", 32'(abt), 0);

    // R4 flush, idle
    wr(0, 32'h01);
    chk("R4 flush en", 32'(en), 1);
    chk("R4 flush abort", 32'(abt), 0);
    rchk("R4 flush wcnt", 3, 32'h1C);
    rchk("R4 flush stat", 5, 0);
    wr(0, 32'h00);
    chk("R4 idle en", 32'(en), 0);

    // R9 completion
    pulse_done();
    rchk("R9 wcnt", 3, 0);
    rchk("R9 stat", 5, 32'h08);

    // R12 live interrupt bit
    irq = 1; rchk("R12 irq on", 5, 32'h18);
    irq = 0; rchk("R12 irq off", 5, 32'h08);

    // R10 write-one-to-clear mode
    rc_mode = 0;
    wr(5, 32'h04); rchk("R10 other bit", 5, 32'h08);
    wr(5, 32'h08); rchk("R10 cleared", 5, 0);
    pulse_done();
    wr(5, 32'h3F); rchk("R10 all ones", 5, 0);

    // R11 clear-on-read mode
    pulse_done();
    rc_mode = 1;
    wr(5, 32'h08); rchk("R11 write ignored", 5, 32'h08);
    rchk("R11 cleared by read", 5, 0);
    irq = 1; rchk("R11 irq stays live", 5, 32'h10); irq = 0;

    // R3 start clears status
    rc_mode = 0;
    pulse_done();
    wr(0, 32'h03);
    rchk("R3 stat cleared", 5, 0);
    rd(3, d); chk("R3 reload wcnt", d, 32'h20);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  logic [15:0] len_list [6] = '{16'd5, 16'd0, 16'd17, 16'd30, 16'd100, 16'd3};
endmodule